// File: doc/BRIEF.md
# Resolver Feedback Health Monitor

This block watches the demodulated sine and cosine envelopes of a resolver together with the angle error of the tracking loop that follows them, and raises two sticky alarms. The amplitude alarm relies on the identity that the squared sine plus the squared cosine is a constant for a healthy winding pair. The sum is formed at full width for every accepted sample and must fall inside a window of nominal plus or minus tolerance. An open or degraded winding pulls the sum out of that window. The loop alarm fires when the magnitude of the signed angle error exceeds a limit, which means the tracking loop is losing lock.

Each alarm has a persistence count, so an isolated rogue sample does not raise it. Any good sample restarts the count. Once raised, an alarm stays high until software pulses the clear input.

Samples arrive on a valid/ready stream. The monitor never exerts back-pressure: ready is low only during reset and high on every cycle after it. A sample is taken on any rising edge where valid and ready are both high. The upstream source may hold valid high on consecutive cycles.

Top module: `resolver_health_mon`

## Requirements
- R1: `smp_ready` is 0 while reset is asserted and 1 on every cycle after reset is released; samples are never back-pressured.
- R2: For each accepted sample, the unsigned sum sin*sin + cos*cos is formed without truncation. This includes the extreme (-2^(SIG_W-1))^2 + (-2^(SIG_W-1))^2 = 2^(2*SIG_W-1).
- R3: A sample is an amplitude violation when its sum is below `cfg_nominal - cfg_tol` or above `cfg_nominal + cfg_tol`. Both bounds count as in-window.
- R4: A sample is a loop violation when |err| is strictly greater than `cfg_err_limit`. The most negative error value (-2^(ERR_W-1)) is taken as magnitude 2^(ERR_W-1)-1.
- R5: An alarm rises once `cfg_persist` consecutive accepted samples violate its check. A `cfg_persist` of 0 behaves as 1. The alarm is visible from the second rising edge after the sample that completes the run is accepted.
- R6: A non-violating accepted sample resets that check's consecutive count. Cycles without an accepted sample neither advance nor reset the count.
- R7: `amp_fault` and `loop_fault` stay high until `clr_faults` is sampled high. A clear drops both alarms and both counts at the next edge, and this overrides any update at that same edge.
- R8: After reset, both alarms are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready (high after reset) |
| smp_sin | input | SIG_W | Signed sine envelope |
| smp_cos | input | SIG_W | Signed cosine envelope |
| smp_err | input | ERR_W | Signed wrapped loop angle error |
| cfg_nominal | input | 2*SIG_W | Expected sum of squares |
| cfg_tol | input | 2*SIG_W | Allowed deviation from nominal |
| cfg_err_limit | input | ERR_W-1 | Largest error magnitude still accepted |
| cfg_persist | input | CNT_W | Consecutive violations needed for an alarm |
| clr_faults | input | 1 | Clear strobe for both alarms |
| amp_fault | output | 1 | Sticky amplitude alarm |
| loop_fault | output | 1 | Sticky loop-loss alarm |

## Verification
The assertions assume that the configuration inputs stay steady while samples are in flight. They also assume that `clr_faults` is not pulsed on the edge where a violating sample would raise an alarm. The stimulus keeps to both rules. It changes the nominal, tolerance, limit and persistence values only while the pipeline is idle, and it pulses the clear only after the flags have been sampled. The amplitude sweep walks a grid across the whole signed sine and cosine range with a persistence of 1. The error sweep covers every error code. Separate runs cover the window bounds, full-width extremes, gaps between samples and counter restarts.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
  // Index of each supervised check inside the alarm vector
  localparam int KIND_AMP  = 0;
  localparam int KIND_LOOP = 1;
  localparam int N_KINDS   = 2;

  function automatic int sq_width(input int sig_w);
    return 2 * sig_w;
  endfunction
endpackage

// File: rtl/rhm_square_stage.sv
module rhm_square_stage #(
  parameter int SIG_W = 8,
  parameter int ERR_W = 8,
  localparam int SQ_W = rhm_pkg::sq_width(SIG_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic signed [SIG_W-1:0] sin_in,
  input  logic signed [SIG_W-1:0] cos_in,
  input  logic signed [ERR_W-1:0] err_in,
  output logic                    s1_valid,
  output logic [SQ_W-1:0]         s1_sum,
  output logic [ERR_W-2:0]        s1_mag
);
  localparam logic [ERR_W-1:0] ERR_MIN = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic [ERR_W-2:0] MAG_MAX = {(ERR_W-1){1'b1}};

  logic signed [SQ_W-1:0] sin_x, cos_x, p_sin, p_cos;
  logic [SQ_W-1:0]        sum_c;
  logic [ERR_W-1:0]       neg_e;
  logic [ERR_W-2:0]       mag_c;

  // Sign-extend first so the product is computed at full width
  assign sin_x = {{SIG_W{sin_in[SIG_W-1]}}, sin_in};
  assign cos_x = {{SIG_W{cos_in[SIG_W-1]}}, cos_in};
  assign p_sin = sin_x * sin_x;
  assign p_cos = cos_x * cos_x;
  assign sum_c = p_sin + p_cos;

  assign neg_e = -err_in;

  always_comb begin
    if (err_in == ERR_MIN)       mag_c = MAG_MAX;
    else if (err_in[ERR_W-1])    mag_c = neg_e[ERR_W-2:0];
    else                         mag_c = err_in[ERR_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sum   <= '0;
      s1_mag   <= '0;
    end else begin
      s1_valid <= take;
      if (take) begin
        s1_sum <= sum_c;
        s1_mag <= mag_c;
      end
    end
  end
endmodule

// File: rtl/rhm_window_cmp.sv
module rhm_window_cmp #(
  parameter int SQ_W = 16
) (
  input  logic [SQ_W-1:0] sum,
  input  logic [SQ_W-1:0] nominal,
  input  logic [SQ_W-1:0] tol,
  output logic            outside
);
  logic [SQ_W:0] sum_w, nom_w, tol_w;
  logic          above_lo, below_hi;

  assign sum_w = {1'b0, sum};
  assign nom_w = {1'b0, nominal};
  assign tol_w = {1'b0, tol};

  // One extra bit keeps nominal+tol and sum+tol from wrapping
  assign above_lo = (sum_w + tol_w) >= nom_w;
  assign below_hi = sum_w <= (nom_w + tol_w);
  assign outside  = !(above_lo && below_hi);
endmodule

// File: rtl/rhm_persist_flag.sv
module rhm_persist_flag #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             bad,
  input  logic [CNT_W-1:0] persist,
  input  logic             clr,
  output logic             flag
);
  logic [CNT_W-1:0] run_q, run_inc, need;

  assign need    = (persist == '0) ? CNT_W'(1) : persist;
  assign run_inc = (run_q == {CNT_W{1'b1}}) ? run_q : run_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      flag  <= 1'b0;
    end else if (clr) begin
      run_q <= '0;
      flag  <= 1'b0;
    end else if (upd) begin
      if (bad) begin
        run_q <= run_inc;
        if (run_inc >= need) flag <= 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/resolver_health_mon.sv
module resolver_health_mon #(
  parameter int SIG_W = 8,
  parameter int ERR_W = 8,
  parameter int CNT_W = 4,
  localparam int SQ_W = rhm_pkg::sq_width(SIG_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic signed [SIG_W-1:0] smp_sin,
  input  logic signed [SIG_W-1:0] smp_cos,
  input  logic signed [ERR_W-1:0] smp_err,
  input  logic [SQ_W-1:0]         cfg_nominal,
  input  logic [SQ_W-1:0]         cfg_tol,
  input  logic [ERR_W-2:0]        cfg_err_limit,
  input  logic [CNT_W-1:0]        cfg_persist,
  input  logic                    clr_faults,
  output logic                    amp_fault,
  output logic                    loop_fault
);
  logic                    rdy_q;
  logic                    take;
  logic                    s1_valid;
  logic [SQ_W-1:0]         s1_sum;
  logic [ERR_W-2:0]        s1_mag;
  logic [rhm_pkg::N_KINDS-1:0] bad_v, flag_v;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign smp_ready = rdy_q;
  assign take      = smp_valid && rdy_q;

  rhm_square_stage #(.SIG_W(SIG_W), .ERR_W(ERR_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .take(take),
    .sin_in(smp_sin), .cos_in(smp_cos), .err_in(smp_err),
    .s1_valid(s1_valid), .s1_sum(s1_sum), .s1_mag(s1_mag)
  );

  rhm_window_cmp #(.SQ_W(SQ_W)) u_win (
    .sum(s1_sum), .nominal(cfg_nominal), .tol(cfg_tol),
    .outside(bad_v[rhm_pkg::KIND_AMP])
  );

  assign bad_v[rhm_pkg::KIND_LOOP] = s1_mag > cfg_err_limit;

  for (genvar k = 0; k < rhm_pkg::N_KINDS; k++) begin : g_alarm
    rhm_persist_flag #(.CNT_W(CNT_W)) u_pf (
      .clk(clk), .rst_n(rst_n), .upd(s1_valid), .bad(bad_v[k]),
      .persist(cfg_persist), .clr(clr_faults), .flag(flag_v[k])
    );
  end

  assign amp_fault  = flag_v[rhm_pkg::KIND_AMP];
  assign loop_fault = flag_v[rhm_pkg::KIND_LOOP];
endmodule

// File: rtl/rhm_chk.sv
module rhm_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [ERR_W-1:0] smp_err,
  input logic             clr_faults,
  input logic             amp_fault,
  input logic             loop_fault,
  input logic             s1_valid,
  input logic [ERR_W-2:0] s1_mag
);
  localparam logic [ERR_W-1:0] ERR_MIN = {1'b1, {(ERR_W-1){1'b0}}};

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> smp_ready);

  // R4
  min_err_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && smp_err == ERR_MIN) |=> (s1_mag == {(ERR_W-1){1'b1}}));

  // R5
  amp_rise_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_fault) |-> $past(s1_valid));

  // R5
  loop_rise_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_fault) |-> $past(s1_valid));

  // R7
  amp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_fault && !clr_faults) |=> amp_fault);

  // R7
  loop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_fault && !clr_faults) |=> loop_fault);

  // R7
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_faults |=> (!amp_fault && !loop_fault));
endmodule

bind resolver_health_mon rhm_chk #(.ERR_W(ERR_W)) u_rhm_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_err(smp_err), .clr_faults(clr_faults), .amp_fault(amp_fault),
  .loop_fault(loop_fault), .s1_valid(s1_valid), .s1_mag(s1_mag)
);

// File: tb/test_resolver_health_mon.sv
module test_resolver_health_mon;
  localparam int SW = 8;
  localparam int EW = 8;
  localparam int CW = 4;
  localparam int QW = 2 * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic signed [SW-1:0] smp_sin = '0;
  logic signed [SW-1:0] smp_cos = '0;
  logic signed [EW-1:0] smp_err = '0;
  logic [QW-1:0] cfg_nominal = '0;
  logic [QW-1:0] cfg_tol = '0;
  logic [EW-2:0] cfg_err_limit = '0;
  logic [CW-1:0] cfg_persist = CW'(1);
  logic clr_faults = 1'b0;
  logic amp_fault, loop_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  resolver_health_mon #(.SIG_W(SW), .ERR_W(EW), .CNT_W(CW)) i_resolver_health_mon (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_sin(smp_sin), .smp_cos(smp_cos), .smp_err(smp_err),
    .cfg_nominal(cfg_nominal), .cfg_tol(cfg_tol), .cfg_err_limit(cfg_err_limit),
    .cfg_persist(cfg_persist), .clr_faults(clr_faults),
    .amp_fault(amp_fault), .loop_fault(loop_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one sample; returns at the negedge where the alarms reflect it
  task automatic push(input int s, input int c, input int e);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_sin = SW'(s);
    smp_cos = SW'(c);
    smp_err = EW'(e);
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk);
    clr_faults = 1'b1;
    @(negedge clk);
    clr_faults = 1'b0;
  endtask

  function automatic int outside(input int sum, input int nom, input int tol);
    return ((sum < nom - tol) || (sum > nom + tol)) ? 1 : 0;
  endfunction

  function automatic int mag_of(input int e);
    if (e == -(1 << (EW - 1))) return (1 << (EW - 1)) - 1;
    return (e < 0) ? -e : e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(smp_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 amp after reset", int'(amp_fault), 0);
    chk("R8 loop after reset", int'(loop_fault), 0);
    chk("R1 ready after reset", int'(smp_ready), 1);

    // R2 R3: grid sweep over signed envelope range, persistence 1
    cfg_nominal = QW'(8000);
    cfg_tol = QW'(2000);
    cfg_err_limit = '1;
    for (int s = -128; s < 128; s += 8) begin
      for (int c = -128; c < 128; c += 8) begin
        int exp;
        push(s, c, 0);
        exp = outside(s * s + c * c, 8000, 2000);
        chk($sformatf("R3 sweep s=%0d c=%0d", s, c), int'(amp_fault), exp);
        if (amp_fault) clear();
      end
    end

    // R3 window bounds: sum 60^2+80^2 = 10000
    cfg_nominal = QW'(10000); cfg_tol = '0;
    push(60, 80, 0); chk("R3 exact nominal", int'(amp_fault), 0);
    cfg_nominal = QW'(10001);
    push(60, 80, 0); chk("R3 one below", int'(amp_fault), 1); clear();
    cfg_nominal = QW'(9999); cfg_tol = QW'(1);
    push(60, 80, 0); chk("R3 upper bound inclusive", int'(amp_fault), 0);
    cfg_nominal = QW'(10002); cfg_tol = QW'(2);
    push(60, 80, 0); chk("R3 lower bound inclusive", int'(amp_fault), 0);
    cfg_nominal = QW'(9998); cfg_tol = QW'(1);
    push(60, 80, 0); chk("R3 one above", int'(amp_fault), 1); clear();

    // R2 full width extremes: 32768 and 16384
    cfg_nominal = QW'(32768); cfg_tol = '0;
    push(-128, -128, 0); chk("R2 full-width max sum", int'(amp_fault), 0);
    cfg_nominal = QW'(16384);
    push(-128, 0, 0); chk("R2 min square", int'(amp_fault), 0);
    push(0, 0, 0); chk("R2 zero sum out", int'(amp_fault), 1); clear();

    // R4: every error code with limit 50, amplitude in window
    cfg_nominal = '0; cfg_tol = '0; cfg_err_limit = EW'(50) > 0 ? 7'(50) : '0;
    for (int e = -128; e < 128; e++) begin
      int exp;
      push(0, 0, e);
      exp = (mag_of(e) > 50) ? 1 : 0;
      chk($sformatf("R4 err=%0d", e), int'(loop_fault), exp);
      chk($sformatf("R3 amp quiet err=%0d", e), int'(amp_fault), 0);
      if (loop_fault) clear();
    end
    cfg_err_limit = 7'(127);
    push(0, 0, -128); chk("R4 min error saturates", int'(loop_fault), 0);
    cfg_err_limit = 7'(126);
    push(0, 0, -128); chk("R4 saturated above 126", int'(loop_fault), 1); clear();

    // R5 R6 persistence 3 on the loop check, idle gaps in between
    cfg_err_limit = 7'(50);
    cfg_persist = CW'(3);
    push(0, 0, 100); push(0, 0, 100);
    chk("R5 two of three", int'(loop_fault), 0);
    push(0, 0, 10);
    push(0, 0, 100); repeat (5) @(negedge clk); push(0, 0, 100);
    chk("R6 good sample restarted run", int'(loop_fault), 0);
    repeat (4) @(negedge clk);
    push(0, 0, -100);
    chk("R5 third consecutive raises", int'(loop_fault), 1);

    // R7 sticky across good samples, then clear
    push(0, 0, 0); push(0, 0, 0);
    chk("R7 sticky loop", int'(loop_fault), 1);
    clear();
    chk("R7 cleared loop", int'(loop_fault), 0);
    push(0, 0, 100); push(0, 0, 100);
    chk("R7 clear reset count", int'(loop_fault), 0);
    clear();

    // R5 persistence 0 acts as 1, on the amplitude check
    cfg_persist = '0;
    push(5, 5, 0);
    chk("R5 persist zero as one", int'(amp_fault), 1);
    chk("R5 loop untouched", int'(loop_fault), 0);
    clear();
    chk("R7 cleared amp", int'(amp_fault), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule